// File: doc/BRIEF.md
# Mixed Stream and PWM Pattern Output Stage

This block drives a set of digital output pins from a single sample clock. Each pin has its own source. In stream mode, the pin replays that channel's bit from an incoming sample stream. In counter mode, the pin is driven by a free-running period/high-time counter that makes a periodic, clock-like waveform.

A slow rectangular wave can be made by a counter while a fast pattern is streamed on the other pins. The stream then never has to hold a common multiple of unrelated periods. A single start pulse launches the stream acceptance and every counter in the same clock, so all channels begin in phase. A stop pulse returns all pins to low.

Sample stream back-pressure works as follows. `smp_ready` is high only while the stage runs, or during the start cycle itself, and it is forced low whenever stop is high. A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. When no sample arrives, the stream channels keep their last value. The source may hold `smp_valid` high for as long as it likes.

Top module: `pattern_out_top`

## Requirements
- R1: After reset, every bit of `pat_out` is low and `smp_ready` is low.
- R2: Each channel's source is chosen by its own mode register, written with `cfg_sel`=0 and `cfg_wdata[0]` (0 = stream, 1 = counter). A mode change while running affects only that channel and shows on `pat_out` after the write edge.
- R3: In stream mode, `pat_out[i]` equals bit i of the last accepted sample, from the cycle after the edge that accepted it.
- R4: When no sample is accepted (`smp_valid` low), stream-mode outputs hold their previous value.
- R5: `smp_ready` is high only while running, or while `start` is high without `stop`. Samples offered while stopped are not taken, and the outputs stay low.
- R6: In counter mode with period P (`cfg_sel`=1) and high time H (`cfg_sel`=2), let k be the number of clocks since the start edge, with k=0 in the cycle after it. The output is high when (k mod P) < H and low otherwise. A P of 0 acts as 1.
- R7: A high time of 0 gives a constantly low output. A high time of P or more gives a constantly high output.
- R8: A period or high-time write made while a counter runs is used only from that counter's next wrap to zero.
- R9: The start edge loads all counters to zero phase and accepts the first sample, so both first appear in the same cycle.
- R10: A stop pulse forces all outputs low from the next cycle on and returns the counters to zero. When stop and start are high together, stop wins.
- R11: Periods up to 2^CNT_W-1 are supported. For example, P=30008 with H=8000 gives high at k=7999, low at k=8000 and k=30007, and high again at k=30008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse shared by all channels |
| stop | input | 1 | Stop pulse; takes priority over start |
| smp_valid | input | 1 | Stream sample is present |
| smp_ready | output | 1 | Stream sample can be accepted |
| smp_data | input | NCH | One bit per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Target channel |
| cfg_sel | input | 2 | 0 = mode, 1 = period, 2 = high time |
| cfg_wdata | input | CNT_W | Write data |
| pat_out | output | NCH | Channel output pins |

## Verification
Every result is due exactly one clock edge after its cause. The start edge gives phase k=0 in the next cycle. An accepted sample shows after its accepting edge. A mode write shows after its write edge. A stop clears the pins after its edge. A held period or high-time write appears at the first wrap after the write edge. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the start edge, so each expected value comes from k mod P, with the pending settings applied only from the wrap index onward.

// File: rtl/pattern_out_pkg.sv
package pattern_out_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_HIGH   = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/pat_cfg_regs.sv
module pat_cfg_regs #(
  parameter int NCH   = 4,
  parameter int CNT_W = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [CH_W-1:0]            ch,
  input  logic [1:0]                 sel,
  input  logic [CNT_W-1:0]           wdata,
  output logic [NCH-1:0]             mode_cnt,
  output logic [NCH-1:0][CNT_W-1:0]  per_pend,
  output logic [NCH-1:0][CNT_W-1:0]  hi_pend
);
  import pattern_out_pkg::*;

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    logic hit;
    assign hit = we && (ch == CH_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_cnt[i] <= 1'b0;
        per_pend[i] <= '0;
        hi_pend[i]  <= '0;
      end else if (hit) begin
        case (cfg_sel_e'(sel))
          SEL_MODE:   mode_cnt[i] <= wdata[0];
          SEL_PERIOD: per_pend[i] <= wdata;
          SEL_HIGH:   hi_pend[i]  <= wdata;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pat_pwm_chan.sv
module pat_pwm_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic             running,
  input  logic [CNT_W-1:0] per_pend,
  input  logic [CNT_W-1:0] hi_pend,
  output logic             wave
);
  logic [CNT_W-1:0] cnt, per_act, hi_act;
  logic             wrap;

  assign wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, per_act};
  assign wave = running && (cnt < hi_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= '0;
      hi_act  <= '0;
    end else if (halt) begin
      cnt <= '0;
    end else if (go || (running && wrap)) begin
      cnt     <= '0;
      per_act <= per_pend;
      hi_act  <= hi_pend;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cnt == '0) else $error("counter not parked");  // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (running && per_act > 1) |-> cnt < per_act) else $error("count past period");  // R6
  AST_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && cnt != '0) |-> ($stable(hi_act) && $stable(per_act)))
    else $error("settings changed mid period");  // R8
endmodule

// File: rtl/pat_stream_stage.sv
module pat_stream_stage #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           clr,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (take)     q <= din;
  end

  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> $stable(q)) else $error("stream value moved");  // R4
endmodule

// File: rtl/pattern_out_top.sv
module pattern_out_top #(
  parameter int NCH   = 4,
  parameter int CNT_W = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [NCH-1:0]   smp_data,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [NCH-1:0]   pat_out
);
  logic                      running, go, take;
  logic [NCH-1:0]            mode_cnt, wave, strm_q;
  logic [NCH-1:0][CNT_W-1:0] per_pend, hi_pend;

  assign go        = start && !stop;
  assign smp_ready = (running || start) && !stop;
  assign take      = smp_valid && smp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || stop) running <= 1'b0;
    else if (start)     running <= 1'b1;
  end

  pat_cfg_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .ch(cfg_ch), .sel(cfg_sel),
    .wdata(cfg_wdata), .mode_cnt(mode_cnt), .per_pend(per_pend), .hi_pend(hi_pend)
  );

  pat_stream_stage #(.NCH(NCH)) u_strm (
    .clk(clk), .rst_n(rst_n), .take(take), .clr(stop), .din(smp_data), .q(strm_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pat_pwm_chan #(.CNT_W(CNT_W)) u_pwm (
      .clk(clk), .rst_n(rst_n), .go(go), .halt(stop), .running(running),
      .per_pend(per_pend[i]), .hi_pend(hi_pend[i]), .wave(wave[i])
    );
    assign pat_out[i] = running && (mode_cnt[i] ? wave[i] : strm_q[i]);
  end

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> pat_out == '0) else $error("outputs alive after stop");  // R10
  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |-> !smp_ready) else $error("ready while stopped");  // R5
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> running) else $error("start ignored");  // R9
endmodule

// File: tb/pattern_out_top_tb_top.sv
module pattern_out_top_tb_top;
  localparam int NCH = 4;
  localparam int W   = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic smp_valid = 1'b0, smp_ready, cfg_we = 1'b0;
  logic [NCH-1:0] smp_data = '0, pat_out;
  logic [1:0] cfg_ch = '0, cfg_sel = '0;
  logic [W-1:0] cfg_wdata = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pattern_out_top #(.NCH(NCH), .CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pat_out(pat_out)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int ch, int sel, logic [W-1:0] v);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic go_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic go_stop();
    stop = 1'b1; tick(); stop = 1'b0;
  endtask

  function automatic logic pwm(longint k, longint p, longint h);
    longint pp = (p == 0) ? 1 : p;
    return (k % pp) < h;
  endfunction

  task automatic t_reset();
    chk("R1 out", pat_out, 0);
    chk("R1 ready", smp_ready, 0);
    smp_valid = 1'b1; smp_data = 4'hF; tick();
    chk("R5 ready idle", smp_ready, 0);
    chk("R5 out idle", pat_out, 0);
    smp_valid = 1'b0;
  endtask

  task automatic t_pwm();
    wr(1, 0, 1); wr(1, 1, 5); wr(1, 2, 2);
    wr(2, 0, 1); wr(2, 1, 4); wr(2, 2, 1);
    wr(3, 0, 1); wr(3, 1, 3); wr(3, 2, 0);
    go_start();
    for (int k = 0; k < 20; k++) begin
      chk("R6 ch1", pat_out[1], pwm(k, 5, 2));
      chk("R6 ch2", pat_out[2], pwm(k, 4, 1));
      chk("R7 h0 low", pat_out[3], 0);
      chk("R2 ch0 stream", pat_out[0], 0);
      tick();
    end
    go_stop();
    wr(3, 2, 7);
    go_start();
    for (int k = 0; k < 6; k++) begin
      chk("R7 h>=p high", pat_out[3], 1);
      tick();
    end
    go_stop();
    chk("R10 stopped", pat_out, 0);
  endtask

  task automatic t_stream();
    smp_valid = 1'b1; smp_data = 4'b1011;
    start = 1'b1; tick(); start = 1'b0;
    chk("R9 aligned ch0", pat_out[0], 1);
    chk("R9 aligned ch1", pat_out[1], pwm(0, 5, 2));
    smp_data = 4'b0010; tick();
    chk("R3 new sample", pat_out[0], 0);
    chk("R6 ch1 k1", pat_out[1], pwm(1, 5, 2));
    smp_valid = 1'b0; smp_data = 4'b1111; tick();
    chk("R4 hold", pat_out[0], 0);
    wr(1, 0, 0);
    chk("R2 ch1 to stream", pat_out[1], 1);
    chk("R2 ch2 untouched", pat_out[2], pwm(3, 4, 1));
    tick();
    chk("R4 hold2", pat_out[1:0], 2'b10);
    go_stop();
    chk("R10 stop low", pat_out, 0);
    wr(1, 0, 1);
  endtask

  task automatic t_update();
    wr(1, 1, 5); wr(1, 2, 2);
    go_start();
    tick();
    wr(1, 2, 4);
    for (int k = 2; k < 12; k++) begin
      chk("R8 deferred", pat_out[1], (k < 5) ? pwm(k, 5, 2) : pwm(k, 5, 4));
      tick();
    end
    go_stop();
  endtask

  task automatic t_stop_prio();
    stop = 1'b1; start = 1'b1; smp_valid = 1'b1;
    chk("R10 ready with stop", smp_ready, 0);
    tick();
    stop = 1'b0; start = 1'b0;
    chk("R10 stop wins", pat_out, 0);
    chk("R5 ready stays low", smp_ready, 0);
    smp_valid = 1'b0;
  endtask

  task automatic t_long();
    wr(1, 1, 30008); wr(1, 2, 8000);
    go_start();
    for (int k = 0; k <= 30010; k++) begin
      if (k == 7999 || k == 8000 || k == 30007 || k == 30008)
        chk("R11 long period", pat_out[1], pwm(k, 30008, 8000));
      tick();
    end
    go_stop();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pwm();
    t_stream();
    t_update();
    t_stop_prio();
    t_long();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule